// File: doc/BRIEF.md
# Stereo Gain, Routing and Silence Stage

This block sits between a serial audio receiver and the interpolation filter. Once per frame it takes a left and a right 18-bit two's-complement sample, flagged by a single valid strobe. It forms the two output samples one clock later.

Each output takes its source from a small routing choice: silence, the left input, the right input, or the floored average of both. The source is then scaled by that output's gain, where the gain is an 8-bit code read as x/256 and the top code means exactly unity. A code only reaches the datapath when it is written with its latch bit set. A link control lets the left code govern both outputs.

The applied gain never jumps. It walks one unit per frame toward its target, so latched changes, mute and unmute all fade in or out. A force control and a zero-run detector can both pin the outputs to mid-scale, which is code zero. The detector also drives an active-low zero flag.

Top module: `chan_gain_router`

## Requirements
- R1: The gain for code c is c/256 for c in 0..254 and exactly 1 (256/256) for c = 255. Each output equals floor(source × gain / 256), truncated to 18 bits. After reset both codes are 255 and both applied gains are 256.
- R2: A write (`gainWe` high for one cycle) stores `gainData[7:0]` as the left code when `gainSel` is 0, or as the right code when `gainSel` is 1, only if `gainData[8]` is 1. A write with `gainData[8]` = 0 changes nothing.
- R3: Each applied gain (0..256) moves by exactly one unit toward its target on every frame, after that frame has been scaled with the value it held before the step. Between frames the applied gain does not move.
- R4: When `linkAtt` is 1, the right output's target is derived from the left code and the stored right code is ignored. The stored right code is not lost.
- R5: `routeSel[1:0]` picks the left output's source and `routeSel[3:2]` picks the right output's source. The codes are 00 silence (0), 01 left input, 10 right input, 11 floor((L+R)/2), with the sum formed in 19 bits.
- R6: While `muteReq` is 1, both targets are 0. When it drops, the targets return to the values given by the codes, and the gains ramp per R3.
- R7: While `agForce` is 1, every frame produces `outL` = `outR` = 0 with `midForce` = 1, whatever the inputs are.
- R8: A frame whose two inputs are both zero extends a zero run, and any other frame ends the run. On the 16th consecutive zero frame, `zeroFlagN` goes low together with that frame's outputs. It returns high with the outputs of the first frame that is not all-zero. The flag does not depend on `zeroDetEn`.
- R9: When `zeroDetEn` is 1 and the current frame has completed a run of at least 16, that frame's outputs are 0 and `midForce` is 1. With `zeroDetEn` at 0, `midForce` stays 0 on such frames.
- R10: `outValid` pulses high for one cycle, in the cycle after `inValid`. `outL`, `outR`, `midForce` and `zeroFlagN` hold their values until the next frame.
- R11: After reset, `outValid` = 0, `outL` = `outR` = 0, `midForce` = 0 and `zeroFlagN` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Frame strobe for inL/inR |
| inL | input | 18 | Left input sample, two's complement |
| inR | input | 18 | Right input sample, two's complement |
| gainWe | input | 1 | Gain-code write strobe |
| gainSel | input | 1 | Write target: 0 left code, 1 right code |
| gainData | input | 9 | Bit 8 latch enable, bits 7:0 code |
| linkAtt | input | 1 | Left code drives both outputs |
| routeSel | input | 4 | Source select, [1:0] left output, [3:2] right output |
| muteReq | input | 1 | Fade both outputs to silence |
| agForce | input | 1 | Force both outputs to mid-scale |
| zeroDetEn | input | 1 | Allow a zero run to force mid-scale |
| outValid | output | 1 | Output frame strobe |
| outL | output | 18 | Left output sample |
| outR | output | 18 | Right output sample |
| zeroFlagN | output | 1 | Low while a zero run of 16 or more is active |
| midForce | output | 1 | Outputs of this frame pinned to mid-scale |

## Verification
The hardest condition to reach from the ports is a settled non-trivial gain, because each latched code or mute only reaches the datapath after up to 256 frames of ramping. The bench therefore keeps its own per-output gain and target. It streams non-zero frames and checks every intermediate output, so the ramp itself is compared frame by frame, not only its end point. The link and unmute cases start from gains the earlier scenarios left behind. The zero flag needs exactly sixteen consecutive all-zero frames, so the bench counts them. It checks the 15th and the 16th frame on both sides of the edge, then breaks the run with a single non-zero sample.

// File: rtl/chan_gain_pkg.sv
package chan_gain_pkg;
  localparam int ATT_CODE_W = 8;
  localparam int GAIN_W     = ATT_CODE_W + 1;

  typedef struct packed {
    logic [GAIN_W-1:0] gainL;
    logic [GAIN_W-1:0] gainR;
    logic              forceMid;
  } gainCtrl_t;
endpackage

// File: rtl/chan_gain_ctrl.sv
module chan_gain_ctrl
  import chan_gain_pkg::*;
#(
  parameter int SAMPLE_W = 18,
  parameter int ZERO_RUN = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] inL,
  input  logic signed [SAMPLE_W-1:0] inR,
  input  logic                       gainWe,
  input  logic                       gainSel,
  input  logic [ATT_CODE_W:0]        gainData,
  input  logic                       linkAtt,
  input  logic                       muteReq,
  input  logic                       agForce,
  input  logic                       zeroDetEn,
  output gainCtrl_t                  ctrl,
  output logic                       zeroFlagN
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << ATT_CODE_W);
  localparam int CNT_W = $clog2(ZERO_RUN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(ZERO_RUN);

  logic [ATT_CODE_W-1:0] codeL, codeR;
  logic [GAIN_W-1:0]     gainCurL, gainCurR, tgtL, tgtR;
  logic [CNT_W-1:0]      zeroCnt, cntNext;
  logic                  zeroNow, detNext;

  function automatic logic [GAIN_W-1:0] codeToGain(input logic [ATT_CODE_W-1:0] c);
    return (c == '1) ? UNITY : GAIN_W'(c);
  endfunction

  function automatic logic [GAIN_W-1:0] stepToward(input logic [GAIN_W-1:0] cur,
                                                   input logic [GAIN_W-1:0] tgt);
    if (cur < tgt)      return cur + 1'b1;
    else if (cur > tgt) return cur - 1'b1;
    else                return cur;
  endfunction

  // Latch-gated code storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeL <= '1;
      codeR <= '1;
    end else if (gainWe && gainData[ATT_CODE_W]) begin
      if (gainSel) codeR <= gainData[ATT_CODE_W-1:0];
      else         codeL <= gainData[ATT_CODE_W-1:0];
    end
  end

  always_comb begin
    tgtL = muteReq ? '0 : codeToGain(codeL);
    tgtR = muteReq ? '0 : codeToGain(linkAtt ? codeL : codeR);
  end

  // Per-frame ramp of the applied gains
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainCurL <= UNITY;
      gainCurR <= UNITY;
    end else if (inValid) begin
      gainCurL <= stepToward(gainCurL, tgtL);
      gainCurR <= stepToward(gainCurR, tgtR);
    end
  end

  // Zero-run detection
  always_comb begin
    zeroNow = (inL == '0) && (inR == '0);
    if (!zeroNow)               cntNext = '0;
    else if (zeroCnt == RUN_MAX) cntNext = zeroCnt;
    else                        cntNext = zeroCnt + 1'b1;
    detNext = (cntNext == RUN_MAX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroCnt   <= '0;
      zeroFlagN <= 1'b1;
    end else if (inValid) begin
      zeroCnt   <= cntNext;
      zeroFlagN <= !detNext;
    end
  end

  always_comb begin
    ctrl.gainL    = gainCurL;
    ctrl.gainR    = gainCurR;
    ctrl.forceMid = agForce || (zeroDetEn && detNext);
  end

  AST_RAMP_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (gainCurL == $past(gainCurL)) || (gainCurL == $past(gainCurL) + 1'b1) ||
                (gainCurL + 1'b1 == $past(gainCurL))); // R3
  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(gainCurL) && $stable(gainCurR)); // R3
  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (gainCurL <= UNITY) && (gainCurR <= UNITY)); // R1
endmodule

// File: rtl/chan_gain_path.sv
module chan_gain_path
  import chan_gain_pkg::*;
#(
  parameter int SAMPLE_W = 18
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] inL,
  input  logic signed [SAMPLE_W-1:0] inR,
  input  logic [3:0]                 routeSel,
  input  gainCtrl_t                  ctrl,
  output logic                       outValid,
  output logic signed [SAMPLE_W-1:0] outL,
  output logic signed [SAMPLE_W-1:0] outR,
  output logic                       midForce
);
  localparam int SUM_W  = SAMPLE_W + 1;
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

  logic signed [SUM_W-1:0]    pairSum;
  logic signed [SAMPLE_W-1:0] pairAvg;
  logic signed [SAMPLE_W-1:0] nextOut [2];

  always_comb begin
    pairSum = SUM_W'(inL) + SUM_W'(inR);
    pairAvg = SAMPLE_W'(pairSum >>> 1);
  end

  for (genvar i = 0; i < 2; i++) begin : g_out
    logic [1:0]                 sel;
    logic [GAIN_W-1:0]          gain;
    logic signed [SAMPLE_W-1:0] routed;
    logic signed [PROD_W-1:0]   aExt, bExt, prod;

    always_comb begin
      sel  = routeSel[2*i +: 2];
      gain = (i == 0) ? ctrl.gainL : ctrl.gainR;
      case (sel)
        2'b01:   routed = inL;
        2'b10:   routed = inR;
        2'b11:   routed = pairAvg;
        default: routed = '0;
      endcase
      aExt = PROD_W'(routed);
      bExt = PROD_W'(gain);
      prod = aExt * bExt;
      nextOut[i] = ctrl.forceMid ? '0 : SAMPLE_W'(prod >>> ATT_CODE_W);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outL     <= '0;
      outR     <= '0;
      midForce <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outL     <= nextOut[0];
        outR     <= nextOut[1];
        midForce <= ctrl.forceMid;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outL) && $stable(outR) && $stable(midForce)); // R10
endmodule

// File: rtl/chan_gain_router.sv
module chan_gain_router
  import chan_gain_pkg::*;
#(
  parameter int SAMPLE_W = 18,
  parameter int ZERO_RUN = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] inL,
  input  logic signed [SAMPLE_W-1:0] inR,
  input  logic                       gainWe,
  input  logic                       gainSel,
  input  logic [ATT_CODE_W:0]        gainData,
  input  logic                       linkAtt,
  input  logic [3:0]                 routeSel,
  input  logic                       muteReq,
  input  logic                       agForce,
  input  logic                       zeroDetEn,
  output logic                       outValid,
  output logic signed [SAMPLE_W-1:0] outL,
  output logic signed [SAMPLE_W-1:0] outR,
  output logic                       zeroFlagN,
  output logic                       midForce
);
  gainCtrl_t ctrl;

  chan_gain_ctrl #(.SAMPLE_W(SAMPLE_W), .ZERO_RUN(ZERO_RUN)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inL(inL), .inR(inR),
    .gainWe(gainWe), .gainSel(gainSel), .gainData(gainData),
    .linkAtt(linkAtt), .muteReq(muteReq), .agForce(agForce),
    .zeroDetEn(zeroDetEn), .ctrl(ctrl), .zeroFlagN(zeroFlagN)
  );

  chan_gain_path #(.SAMPLE_W(SAMPLE_W)) u_path (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inL(inL), .inR(inR),
    .routeSel(routeSel), .ctrl(ctrl), .outValid(outValid),
    .outL(outL), .outR(outR), .midForce(midForce)
  );

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R10
  AST_FORCE_PINS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && agForce) |=> midForce && (outL == '0) && (outR == '0)); // R7
  AST_FLAG_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ((inL != '0) || (inR != '0))) |=> zeroFlagN); // R8
  AST_FLAG_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $fell(zeroFlagN) |-> $past(inValid) && ($past(inL) == '0) && ($past(inR) == '0)); // R8
endmodule

// File: tb/chan_gain_router_test.sv
module chan_gain_router_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [17:0] inL = '0, inR = '0;
  logic gainWe = 1'b0, gainSel = 1'b0;
  logic [8:0] gainData = '0;
  logic linkAtt = 1'b0, muteReq = 1'b0, agForce = 1'b0, zeroDetEn = 1'b0;
  logic [3:0] routeSel = 4'b1001;
  logic outValid, zeroFlagN, midForce;
  logic signed [17:0] outL, outR;

  int checks = 0, errors = 0;
  int gL = 256, gR = 256, codeL = 255, codeR = 255, zc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chan_gain_router uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inL(inL), .inR(inR),
    .gainWe(gainWe), .gainSel(gainSel), .gainData(gainData),
    .linkAtt(linkAtt), .routeSel(routeSel), .muteReq(muteReq),
    .agForce(agForce), .zeroDetEn(zeroDetEn), .outValid(outValid),
    .outL(outL), .outR(outR), .zeroFlagN(zeroFlagN), .midForce(midForce)
  );

  function automatic int mapCode(input int c);
    return (c == 255) ? 256 : c;
  endfunction

  function automatic int pickSrc(input int s, input int l, input int r);
    case (s)
      1: return l;
      2: return r;
      3: return (l + r) >>> 1;
      default: return 0;
    endcase
  endfunction

  function automatic int stepTo(input int cur, input int tgt);
    if (cur < tgt) return cur + 1;
    if (cur > tgt) return cur - 1;
    return cur;
  endfunction

  task automatic check(input bit ok, input string what);
    checks++;
    if (!ok) errors++;
    if (!ok) $display("FAIL %s", what);
  endtask

  // One frame: drive, predict from the requirements, compare, advance model
  task automatic frame(input int l, input int r, input string tag);
    int eL, eR, tL, tR;
    bit det, frc;
    zc  = (l == 0 && r == 0) ? ((zc < 16) ? zc + 1 : 16) : 0;
    det = (zc >= 16);
    frc = agForce || (zeroDetEn && det);
    eL  = frc ? 0 : (pickSrc(routeSel[1:0], l, r) * gL) >>> 8;
    eR  = frc ? 0 : (pickSrc(routeSel[3:2], l, r) * gR) >>> 8;
    @(negedge clk);
    inL = 18'(l); inR = 18'(r); inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid && $signed(outL) == eL && $signed(outR) == eR &&
          midForce == frc && zeroFlagN == !det,
          $sformatf("%s: got v=%0b L=%0d R=%0d mid=%0b zfN=%0b expected v=1 L=%0d R=%0d mid=%0b zfN=%0b",
                    tag, outValid, outL, outR, midForce, zeroFlagN, eL, eR, frc, !det));
    tL = muteReq ? 0 : mapCode(codeL);
    tR = muteReq ? 0 : mapCode(linkAtt ? codeL : codeR);
    gL = stepTo(gL, tL);
    gR = stepTo(gR, tR);
  endtask

  task automatic writeCode(input bit sel, input int data);
    @(negedge clk);
    gainWe = 1'b1; gainSel = sel; gainData = 9'(data);
    @(negedge clk);
    gainWe = 1'b0;
    if (data[8]) begin
      if (sel) codeR = data & 255;
      else     codeL = data & 255;
    end
  endtask

  task automatic runFrames(input int n, input int l, input int r, input string tag);
    for (int k = 0; k < n; k++) frame(l, r, tag);
  endtask

  task automatic testReset();
    check(!outValid && outL == 0 && outR == 0 && !midForce && zeroFlagN,
          $sformatf("R11 reset: got v=%0b L=%0d R=%0d mid=%0b zfN=%0b expected 0 0 0 0 1",
                    outValid, outL, outR, midForce, zeroFlagN));
  endtask

  task automatic testRouting();
    logic signed [17:0] keepL;
    routeSel = 4'b1001; frame(1234, -5678, "R5 straight R1 unity");
    routeSel = 4'b0110; frame(1234, -5678, "R5 swapped");
    routeSel = 4'b1111; frame(-3, 0, "R5 average floor");
    routeSel = 4'b1111; frame(131071, 131071, "R5 average full scale");
    routeSel = 4'b0011; frame(-131072, 100, "R5 avg left silence right");
    routeSel = 4'b0100; frame(77, -9, "R5 silence left");
    keepL = outL;
    repeat (3) @(negedge clk);
    check(!outValid && outL == keepL && outR == 18'sd77,
          $sformatf("R10 hold: got v=%0b L=%0d R=%0d expected v=0 L=%0d R=77",
                    outValid, outL, outR, keepL));
    routeSel = 4'b1001;
  endtask

  task automatic testAttenuation();
    writeCode(1'b0, 9'h100 | 128);
    writeCode(1'b1, 9'h100 | 64);
    writeCode(1'b1, 10);              // no latch bit: ignored (R2)
    runFrames(200, 100000, -77777, "R3 ramp to 128/64 R2");
    frame(100000, -77777, "R1 settled 128 and 64");
    writeCode(1'b0, 9'h100 | 254);
    runFrames(130, -131072, 131071, "R1 ramp to 254");
    writeCode(1'b0, 9'h100 | 255);
    runFrames(3, -131072, 131071, "R1 code 255 unity");
  endtask

  task automatic testLink();
    writeCode(1'b0, 9'h100 | 200);
    linkAtt = 1'b1;
    runFrames(200, 50001, -50001, "R4 linked right follows left");
    linkAtt = 1'b0;
    runFrames(140, 50001, -50001, "R4 unlinked back to right code");
  endtask

  task automatic testMute();
    muteReq = 1'b1;
    runFrames(210, 90000, 90000, "R6 fade down");
    frame(90000, -90000, "R6 muted silent");
    muteReq = 1'b0;
    runFrames(80, 90000, -90000, "R6 fade up");
  endtask

  task automatic testForce();
    agForce = 1'b1;
    frame(131071, -131072, "R7 forced mid");
    frame(5, 5, "R7 forced mid again");
    agForce = 1'b0;
    frame(5, 5, "R7 released");
  endtask

  task automatic testZero();
    zeroDetEn = 1'b0;
    runFrames(16, 0, 0, "R8 run without detect enable R9");
    frame(0, 0, "R8 flag beyond run");
    frame(0, 3, "R8 release on nonzero");
    zeroDetEn = 1'b1;
    runFrames(15, 0, 0, "R8 fifteen zero frames");
    frame(0, 0, "R9 sixteenth zero frame forces mid");
    frame(0, 0, "R9 run continues");
    frame(-1, 0, "R8 R9 single nonzero breaks run");
    zeroDetEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testRouting();
    testAttenuation();
    testLink();
    testMute();
    testForce();
    testZero();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule